// File: doc/BRIEF.md
# Load/Store Issue Unit Controller

This block sequences one load or store through a single load/store function unit of an out-of-order core. An issue carries three choices: load or store, immediate or indexed addressing, and whether the computed address is also written back as a second result. From those choices the controller decides which register-file operands to request, adds the base to either the immediate or the index to form the effective address, and then runs a request/response exchange on a valid/ready memory port.

Results leave through two register-file write ports, each with a request/grant handshake. Port 0 returns load data. Port 1 returns the effective address when update is selected. The address writeback runs alongside the memory exchange and is not ordered against it. A grant on port 1 may therefore come while the memory request is still pending, or after the load data is back. The unit stays busy until the memory operation has completed and every write request it raised has been granted.

Top module: `lsu_issue_ctrl`

## Requirements
- R1: After reset `busy` is 0 and `rd_req`, `wr_req` and `mem_req_valid` are all 0. An `issue_valid` seen while idle is accepted, and `busy` is 1 from the next cycle. An `issue_valid` seen while busy is ignored and does not change the operation in progress.
- R2: For a load (`issue_is_store`=0), `rd_req[2]` is never raised. For a store, `rd_req[2]` is raised, and the value latched on its grant appears on `mem_wdata`.
- R3: In immediate mode (`issue_indexed`=0), `rd_req[1]` is never raised and the effective address is base plus `issue_imm`. In indexed mode, `rd_req[1]` is raised and the effective address is base plus the operand-1 value. Both sums are taken modulo 2^XLEN.
- R4: For a load, the data from the cycle with `mem_rsp_valid` is latched and shown on `wr_data0`. From the next cycle `wr_req[0]` is 1, and it stays 1 until `wr_go[0]`. It is 0 in the cycle after the grant.
- R5: For a store, `wr_req[0]` is never raised.
- R6: With update set, `wr_req[1]` rises in the same cycle as `mem_req_valid`, with the effective address on `addr_o`. It holds until `wr_go[1]` and is 0 in the cycle after the grant. Without update, `wr_req[1]` is never raised.
- R7: Every issue raises `rd_req[0]` for the base operand. Each raised `rd_req[i]` stays 1 until `rd_go[i]`, and its operand is captured in the grant cycle. The request is 0 in the cycle after the grant.
- R8: `mem_req_valid` rises only in the cycle after the last required operand was granted. It stays 1 with `mem_addr` unchanged until `mem_req_ready`. `mem_we` is 1 for a store and 0 for a load.
- R9: `busy` stays 1 until the memory operation is complete (store accepted, or load data returned) and all raised write requests have been granted, in either order. The cycle after that, `busy` is 0 and a new issue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | New operation offered |
| issue_is_store | input | 1 | 1 = store, 0 = load |
| issue_indexed | input | 1 | 1 = base+index, 0 = base+immediate |
| issue_update | input | 1 | 1 = write the effective address back |
| issue_imm | input | XLEN | Immediate offset |
| busy | output | 1 | An operation is in progress |
| rd_req | output | 3 | Read requests: [0] base, [1] index, [2] store data |
| rd_go | input | 3 | One-cycle read grants |
| rd_data0 | input | XLEN | Base operand value |
| rd_data1 | input | XLEN | Index operand value |
| rd_data2 | input | XLEN | Store data value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | XLEN | Effective address to memory |
| mem_we | output | 1 | 1 = write (store) |
| mem_wdata | output | XLEN | Store data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | XLEN | Returned load data |
| wr_req | output | 2 | Write requests: [0] load data, [1] effective address |
| wr_go | input | 2 | One-cycle write grants |
| wr_data0 | output | XLEN | Latched load data |
| addr_o | output | XLEN | Latched effective address |

## Verification
The hardest case to reach from the ports is an address writeback granted before the memory side has finished. Getting there needs update set, a memory request held pending by a low `mem_req_ready`, and a `wr_go[1]` pulse during that wait. The bench runs every combination of operation, mode and update, and in the update cases it runs both grant orders: once with the grant inside the held memory request, and once after the load data or store acceptance. It also offers a spurious issue with inverted fields right after each accepted one, and watches every cycle for the requests that the current combination forbids.

// File: rtl/lsu_ctrl_pkg.sv
// Shared types for the load/store issue controller.
// Assumes: three read operands (base, index, store data) and two write
// ports (load data, effective address).
package lsu_ctrl_pkg;

    localparam int NUM_RD = 3;
    localparam int NUM_WR = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_MREQ,
        PH_MRSP,
        PH_FIN
    } lsu_phase_e;

    typedef struct packed {
        logic is_store;
        logic indexed;
        logic update;
    } lsu_op_t;

endpackage

// File: rtl/lsu_rd_collect.sv
// Operand collector: on start it raises a read request for each needed
// operand, captures the operand on its grant and clears that request one
// cycle later. Assumes a grant without a matching request is ignored.
module lsu_rd_collect #(
    parameter int NR   = 3,
    parameter int XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NR-1:0]            need,
    input  logic [NR-1:0]            rd_go,
    input  logic [NR-1:0][XLEN-1:0]  rd_data,
    output logic [NR-1:0]            rd_req,
    output logic [NR-1:0][XLEN-1:0]  opnd,
    output logic                     all_done
);

    // Request flags and operand latches, one slot per operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req <= '0;
            opnd   <= '0;
        end else begin
            for (int i = 0; i < NR; i++) begin
                if (start) begin
                    rd_req[i] <= need[i];
                end else if (rd_req[i] && rd_go[i]) begin
                    rd_req[i] <= 1'b0;
                    opnd[i]   <= rd_data[i];
                end
            end
        end
    end

    // All requested operands have been captured.
    assign all_done = (rd_req == '0);

    for (genvar g = 0; g < NR; g++) begin : g_rd_chk
        AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[g] && rd_go[g] && !start) |=> !rd_req[g]); // R7
    end

endmodule

// File: rtl/lsu_wb_port.sv
// One register-file write request: raised by set and held until the
// one-cycle grant, then dropped. Assumes set and go never arrive together.
module lsu_wb_port (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic go,
    output logic req
);

    // Request flag: set by the sequencer, cleared by the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (set) begin
            req <= 1'b1;
        end else if (req && go) begin
            req <= 1'b0;
        end
    end

    AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && go && !set) |=> !req); // R4

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !go) |=> req); // R6

endmodule

// File: rtl/lsu_agu.sv
// Effective-address adder: base plus index or base plus immediate,
// wrapping modulo 2^XLEN. Purely combinational.
module lsu_agu #(
    parameter int XLEN = 32
) (
    input  logic            indexed,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] ea
);

    // Offset select and add.
    always_comb begin
        ea = base + (indexed ? index : imm);
    end

endmodule

// File: rtl/lsu_issue_ctrl.sv
// Load/store issue controller. It accepts one operation at a time and
// collects its operands. It forms the effective address and runs the
// memory valid/ready exchange. Load data and, if update is set, the
// effective address go back through two write-request ports. The address
// writeback is started with the memory request and runs independently of it.
// Assumes the memory port returns at most one response per load, and
// only after its request was accepted.
module lsu_issue_ctrl #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            issue_is_store,
    input  logic            issue_indexed,
    input  logic            issue_update,
    input  logic [XLEN-1:0] issue_imm,
    output logic            busy,
    output logic [2:0]      rd_req,
    input  logic [2:0]      rd_go,
    input  logic [XLEN-1:0] rd_data0,
    input  logic [XLEN-1:0] rd_data1,
    input  logic [XLEN-1:0] rd_data2,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic [1:0]      wr_req,
    input  logic [1:0]      wr_go,
    output logic [XLEN-1:0] wr_data0,
    output logic [XLEN-1:0] addr_o
);
    import lsu_ctrl_pkg::*;

    lsu_phase_e phase;
    lsu_op_t    op_q;
    logic [XLEN-1:0] imm_q;
    logic [XLEN-1:0] ea_q;
    logic [XLEN-1:0] ld_q;
    logic [XLEN-1:0] ea_sum;

    logic                          accept;
    logic [NUM_RD-1:0]             need;
    logic [NUM_RD-1:0][XLEN-1:0]   rd_bus;
    logic [NUM_RD-1:0][XLEN-1:0]   opnd;
    logic                          rd_done;
    logic [NUM_WR-1:0]             wb_set;

    // Issue acceptance and operand-need decode from the issue fields.
    assign accept = (phase == PH_IDLE) && issue_valid;
    assign need   = {issue_is_store, issue_indexed, 1'b1};
    assign rd_bus = {rd_data2, rd_data1, rd_data0};

    lsu_rd_collect #(.NR(NUM_RD), .XLEN(XLEN)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .need     (need),
        .rd_go    (rd_go),
        .rd_data  (rd_bus),
        .rd_req   (rd_req),
        .opnd     (opnd),
        .all_done (rd_done)
    );

    lsu_agu #(.XLEN(XLEN)) u_agu (
        .indexed (op_q.indexed),
        .base    (opnd[0]),
        .index   (opnd[1]),
        .imm     (imm_q),
        .ea      (ea_sum)
    );

    // Write-port start events: load data on response, address on memory request.
    assign wb_set[0] = (phase == PH_MRSP) && mem_rsp_valid;
    assign wb_set[1] = (phase == PH_READ) && rd_done && op_q.update;

    for (genvar w = 0; w < NUM_WR; w++) begin : g_wb
        lsu_wb_port u_wb (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (wb_set[w]),
            .go    (wr_go[w]),
            .req   (wr_req[w])
        );
    end

    // Phase sequencer with operation, address and load-data latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            op_q  <= '0;
            imm_q <= '0;
            ea_q  <= '0;
            ld_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (issue_valid) begin
                        op_q  <= '{is_store: issue_is_store,
                                   indexed:  issue_indexed,
                                   update:   issue_update};
                        imm_q <= issue_imm;
                        phase <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (rd_done) begin
                        ea_q  <= ea_sum;
                        phase <= PH_MREQ;
                    end
                end
                PH_MREQ: begin
                    if (mem_req_ready) begin
                        phase <= op_q.is_store ? PH_FIN : PH_MRSP;
                    end
                end
                PH_MRSP: begin
                    if (mem_rsp_valid) begin
                        ld_q  <= mem_rsp_data;
                        phase <= PH_FIN;
                    end
                end
                PH_FIN: begin
                    if (wr_req == '0) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output drive from the latched state.
    assign busy          = (phase != PH_IDLE);
    assign mem_req_valid = (phase == PH_MREQ);
    assign mem_addr      = ea_q;
    assign mem_we        = op_q.is_store;
    assign mem_wdata     = opnd[2];
    assign wr_data0      = ld_q;
    assign addr_o        = ea_q;

    AST_NO_RD2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q.is_store) |-> !rd_req[2]); // R2

    AST_NO_RD1_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q.indexed) |-> !rd_req[1]); // R3

    AST_NO_WR0_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q.is_store) |-> !wr_req[0]); // R5

    AST_NO_WR1_NOUPD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q.update) |-> !wr_req[1]); // R6

    AST_MEM_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (rd_req == '0)); // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wr_req == '0 && rd_req == '0 && !mem_req_valid)); // R9

    AST_BASE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rd_req[0]); // R7

endmodule

// File: tb/lsu_issue_ctrl_test.sv
// Self-checking bench: every operation/mode/update combination, with both
// writeback orders when update is set.
module lsu_issue_ctrl_test;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0, issue_is_store = 1'b0, issue_indexed = 1'b0, issue_update = 1'b0;
    logic [XLEN-1:0] issue_imm = '0;
    logic busy;
    logic [2:0] rd_req;
    logic [2:0] rd_go = '0;
    logic [XLEN-1:0] rd_data0 = '0, rd_data1 = '0, rd_data2 = '0;
    logic mem_req_valid, mem_we;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [XLEN-1:0] mem_addr, mem_wdata, wr_data0, addr_o;
    logic [XLEN-1:0] mem_rsp_data = '0;
    logic [1:0] wr_req;
    logic [1:0] wr_go = '0;

    int errors = 0;
    int checks = 0;
    int viol = 0;
    bit finished = 0;
    bit cur_st = 0, cur_idx = 0, cur_upd = 0;

    lsu_issue_ctrl #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_is_store(issue_is_store),
        .issue_indexed(issue_indexed), .issue_update(issue_update),
        .issue_imm(issue_imm), .busy(busy),
        .rd_req(rd_req), .rd_go(rd_go),
        .rd_data0(rd_data0), .rd_data1(rd_data1), .rd_data2(rd_data2),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wr_req(wr_req), .wr_go(wr_go), .wr_data0(wr_data0), .addr_o(addr_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Forbidden-request monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cur_st && rd_req[2]) viol++;
            if (!cur_idx && rd_req[1]) viol++;
            if (cur_st && wr_req[0]) viol++;
            if (!cur_upd && wr_req[1]) viol++;
        end
    end

    // Pulse one write grant and confirm its request drops the cycle after.
    task automatic grant_wr(input int w, input string tag);
        chk(wr_req[w] == 1'b1, tag, {31'b0, wr_req[w]}, 1);
        wr_go[w] = 1'b1;
        @(negedge clk);
        wr_go[w] = 1'b0;
        chk(wr_req[w] == 1'b0, tag, {31'b0, wr_req[w]}, 0);
    endtask

    task automatic run_op(input bit st, input bit idx, input bit upd, input bit early,
                          input logic [XLEN-1:0] base, input logic [XLEN-1:0] index,
                          input logic [XLEN-1:0] imm, input logic [XLEN-1:0] sdata,
                          input logic [XLEN-1:0] ldata);
        logic [XLEN-1:0] ea;
        int n;
        ea = base + (idx ? index : imm);
        cur_st = st; cur_idx = idx; cur_upd = upd;
        viol = 0;
        issue_valid = 1'b1; issue_is_store = st; issue_indexed = idx;
        issue_update = upd; issue_imm = imm;
        @(negedge clk);
        // R1: accepted, busy next cycle; spurious issue with inverted fields
        chk(busy == 1'b1, "R1 busy after issue", {31'b0, busy}, 1);
        chk(rd_req == {st, idx, 1'b1}, "R7 R2 R3 read requests",
            {29'b0, rd_req}, {29'b0, st, idx, 1'b1});
        issue_is_store = ~st; issue_indexed = ~idx; issue_update = ~upd;
        issue_imm = ~imm;
        @(negedge clk);
        issue_valid = 1'b0;
        // R7: grant operands one at a time, highest first
        for (int i = 2; i >= 0; i--) begin
            if (i == 0 || (i == 1 && idx) || (i == 2 && st)) begin
                rd_data0 = (i == 0) ? base : 32'hDEAD_0000;
                rd_data1 = (i == 1) ? index : 32'hDEAD_0001;
                rd_data2 = (i == 2) ? sdata : 32'hDEAD_0002;
                rd_go[i] = 1'b1;
                @(negedge clk);
                rd_go[i] = 1'b0;
                chk(rd_req[i] == 1'b0, "R7 read request drop", {31'b0, rd_req[i]}, 0);
                chk(mem_req_valid == 1'b0, "R8 no memory request before operands",
                    {31'b0, mem_req_valid}, 0);
            end
        end
        n = 0;
        while (!mem_req_valid && n < 5) begin
            @(negedge clk);
            n++;
        end
        chk(n == 1, "R8 memory request one cycle after last grant", n, 1);
        chk(mem_addr == ea, "R3 effective address", mem_addr, ea);
        chk(mem_we == st, "R8 write enable", {31'b0, mem_we}, {31'b0, st});
        if (st) chk(mem_wdata == sdata, "R2 store data", mem_wdata, sdata);
        if (upd) begin
            chk(wr_req[1] == 1'b1, "R6 update request with memory request",
                {31'b0, wr_req[1]}, 1);
            chk(addr_o == ea, "R6 writeback address", addr_o, ea);
        end
        // R6: early grant while the memory request is held
        if (upd && early) grant_wr(1, "R6 early update grant");
        @(negedge clk);
        chk(mem_req_valid == 1'b1 && mem_addr == ea, "R8 request held",
            mem_addr, ea);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (!st) begin
            chk(busy == 1'b1, "R9 busy waiting for load data", {31'b0, busy}, 1);
            mem_rsp_data = ldata;
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data = 32'hBAD0_BAD0;
            chk(wr_data0 == ldata, "R4 load data latched", wr_data0, ldata);
            chk(wr_req[0] == 1'b1, "R4 load write request", {31'b0, wr_req[0]}, 1);
            @(negedge clk);
            chk(wr_req[0] == 1'b1, "R4 request held", {31'b0, wr_req[0]}, 1);
            grant_wr(0, "R4 load grant");
        end
        if (upd && !early) begin
            chk(busy == 1'b1, "R9 busy until update granted", {31'b0, busy}, 1);
            grant_wr(1, "R6 late update grant");
        end
        n = 0;
        while (busy && n < 5) begin
            @(negedge clk);
            n++;
        end
        chk(n == 1, "R9 idle one cycle after completion", n, 1);
        chk(viol == 0, "R2 R3 R5 R6 forbidden requests", viol, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && rd_req == 0 && wr_req == 0 && mem_req_valid == 0,
            "R1 reset state", {27'b0, busy, rd_req, mem_req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++)
            for (int x = 0; x < 2; x++)
                for (int u = 0; u < 2; u++)
                    for (int e = 0; e < 2; e++) begin
                        if (u == 0 && e == 1) continue;
                        run_op(s[0], x[0], u[0], e[0],
                               32'h1000_0000 + 32'(s * 256 + x * 16 + u * 4 + e),
                               32'h0000_0400 + 32'(x * 8),
                               32'h0000_0040 + 32'(u * 2),
                               32'hC0DE_0000 + 32'(s + x + u),
                               32'hA5A5_0000 + 32'(x * 4 + u * 2 + e));
                    end
        // R3: address wrap-around in both modes
        run_op(1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020,
               32'h0, 32'h1234_5678);
        run_op(1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FF00, 32'h0000_0104, 32'h0,
               32'h8765_4321, 32'h0);
        summary();
    end
endmodule